// File: doc/BRIEF.md
# Power Mode and Clock Controller

This block sets the operating mode of a small processor core. Software writes an 8-bit mode register. The block decodes that register into one of seven legal modes. From the mode it drives three things: the enables for a fast and a slow oscillator, the choice of system clock source with a run/stop gate, and a halt line to the CPU.

While the CPU is halted, the block watches the interrupt request and enable vectors, the global enable and the current mask level. A qualifying interrupt ends a halt in the next cycle. Halt modes return to the running mode that uses the same clock. Stop modes first restart the oscillator the target mode needs. They then keep the CPU halted for a programmable number of settling cycles, and only after that hand control back.

A change of clock source is committed only on a cycle where both sampled clock levels are low. This keeps the downstream multiplexer from cutting a pulse short.

Top module: `pmc_ctrl`

## Requirements
- R1: After reset the register reads 0x00, both oscillator enables are 1, the clock source is fast (`clk_sel_ls_o`=0), the clock runs and the CPU is not halted.
- R2: Register bit 3 is the stop bit, bit 2 the halt bit, bit 1 the slow-select bit and bit 0 the fast-off bit, and bits 7:4 read as zero. A write whose low nibble is a legal code and whose upper nibble is zero is stored and shows on `rd_data_o` after the clock edge that takes it.
- R3: The legal codes are 0000 (NORMAL), 0001 (IDLE), 0011 (SLOW), 0100 (HALT0), 0111 (HALT1), 1000 (STOP0) and 1011 (STOP1). A write of any other value, or of any value with a nonzero upper nibble, leaves the register unchanged.
- R4: The fast oscillator is enabled in NORMAL, IDLE and HALT0. The slow oscillator is enabled in every mode except STOP0 and STOP1.
- R5: The source request is fast in NORMAL and HALT0 and slow in IDLE, SLOW and HALT1. The clock run output is 0 in the stop modes. In those modes the source select holds its last value.
- R6: `cpu_halt_o` is 1 in HALT0, HALT1, STOP0 and STOP1, and 0 in the other modes.
- R7: A wake occurs only when `gie_i` is 1 and some source has request=1, enable=1 and a level numerically below `mask_lvl_i`. Source i uses level bits `irq_lvl_i[3i+2:3i]`.
- R8: A wake in HALT0 sets the mode to NORMAL, and a wake in HALT1 sets it to SLOW, at the same clock edge.
- R9: A wake in STOP0 or STOP1 turns on the target mode's oscillators and keeps the CPU halted with the clock stopped. This lasts for `stab_cnt_i`+1 edges, counted from and including the wake edge, and the mode then becomes NORMAL (from STOP0) or SLOW (from STOP1).
- R10: `clk_sel_ls_o` changes only at an edge where `hs_clk_lvl_i` and `ls_clk_lvl_i` are both 0. The select follows a new request at the first such edge.
- R11: While the CPU is halted, register writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_req_i | input | 4 | Interrupt request flags |
| irq_en_i | input | 4 | Per-source interrupt enables |
| irq_lvl_i | input | 12 | Per-source priority level, 3 bits each |
| gie_i | input | 1 | Global interrupt enable |
| mask_lvl_i | input | 3 | Current interrupt mask level |
| stab_cnt_i | input | 8 | Oscillator settling count for stop exit |
| hs_clk_lvl_i | input | 1 | Sampled level of the fast clock |
| ls_clk_lvl_i | input | 1 | Sampled level of the slow clock |
| hs_osc_en_o | output | 1 | Fast oscillator enable |
| ls_osc_en_o | output | 1 | Slow oscillator enable |
| clk_sel_ls_o | output | 1 | System clock source, 1 = slow |
| clk_run_o | output | 1 | System clock gate enable |
| cpu_halt_o | output | 1 | CPU halt request |

## Verification
The register can be read back, so a corrupted mode code shows on `rd_data_o` at the negative edge after the write. The oscillator, run and halt outputs are combinational from that code, so a wrong decode shows in the same cycle. The source select is registered and a wrong value shows one edge later. A broken wake qualifier or settling counter leaves the CPU halted, or releases it early, at a cycle the bench can predict exactly from `stab_cnt_i`.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_NORMAL = 4'b0000,
    M_IDLE   = 4'b0001,
    M_SLOW   = 4'b0011,
    M_HALT0  = 4'b0100,
    M_HALT1  = 4'b0111,
    M_STOP0  = 4'b1000,
    M_STOP1  = 4'b1011
  } mode_e;

  typedef struct packed {
    logic hs_en;
    logic ls_en;
    logic src_ls;
    logic clk_run;
    logic cpu_halt;
  } ctl_t;

  function automatic logic mode_legal(logic [MODE_W-1:0] c);
    case (c)
      4'b0000, 4'b0001, 4'b0011, 4'b0100,
      4'b0111, 4'b1000, 4'b1011: return 1'b1;
      default:                   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
  import pmc_pkg::*;
(
  input  mode_e mode_i,
  input  logic  stab_i,
  output ctl_t  ctl_o
);
  always_comb begin
    ctl_o = '{hs_en: 1'b1, ls_en: 1'b1, src_ls: 1'b0, clk_run: 1'b1, cpu_halt: 1'b0};
    case (mode_i)
      M_NORMAL: ctl_o = '{hs_en: 1'b1, ls_en: 1'b1, src_ls: 1'b0, clk_run: 1'b1, cpu_halt: 1'b0};
      M_IDLE:   ctl_o = '{hs_en: 1'b1, ls_en: 1'b1, src_ls: 1'b1, clk_run: 1'b1, cpu_halt: 1'b0};
      M_SLOW:   ctl_o = '{hs_en: 1'b0, ls_en: 1'b1, src_ls: 1'b1, clk_run: 1'b1, cpu_halt: 1'b0};
      M_HALT0:  ctl_o = '{hs_en: 1'b1, ls_en: 1'b1, src_ls: 1'b0, clk_run: 1'b1, cpu_halt: 1'b1};
      M_HALT1:  ctl_o = '{hs_en: 1'b0, ls_en: 1'b1, src_ls: 1'b1, clk_run: 1'b1, cpu_halt: 1'b1};
      // settling after stop: bring up the target mode's oscillators, clock still gated
      M_STOP0:  ctl_o = '{hs_en: stab_i, ls_en: stab_i, src_ls: 1'b0, clk_run: 1'b0, cpu_halt: 1'b1};
      M_STOP1:  ctl_o = '{hs_en: 1'b0,   ls_en: stab_i, src_ls: 1'b1, clk_run: 1'b0, cpu_halt: 1'b1};
      default:  ;
    endcase
  end
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int N_IRQ = 4,
  parameter int LVL_W = 3
) (
  input  logic [N_IRQ-1:0]       irq_req_i,
  input  logic [N_IRQ-1:0]       irq_en_i,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl_i,
  input  logic                   gie_i,
  input  logic [LVL_W-1:0]       mask_lvl_i,
  output logic                   wake_o
);
  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign hit[i] = irq_req_i[i] & irq_en_i[i] &
                    (irq_lvl_i[i*LVL_W +: LVL_W] < mask_lvl_i);
  end

  assign wake_o = gie_i & (|hit);
endmodule

// File: rtl/pmc_clk_switch.sv
module pmc_clk_switch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_ls_i,
  input  logic hold_i,
  input  logic hs_lvl_i,
  input  logic ls_lvl_i,
  output logic sel_ls_o
);
  logic sel_q;
  logic both_low;

  assign both_low = ~hs_lvl_i & ~ls_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     sel_q <= 1'b0;
    else if (!hold_i && (want_ls_i != sel_q) && both_low) sel_q <= want_ls_i;
  end

  assign sel_ls_o = sel_q;

  a_r10_switch_at_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> $past(both_low));
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int N_IRQ  = 4,
  parameter int LVL_W  = 3,
  parameter int STAB_W = 8,
  parameter int REG_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [REG_W-1:0]       wr_data_i,
  output logic [REG_W-1:0]       rd_data_o,
  input  logic [N_IRQ-1:0]       irq_req_i,
  input  logic [N_IRQ-1:0]       irq_en_i,
  input  logic [N_IRQ*LVL_W-1:0] irq_lvl_i,
  input  logic                   gie_i,
  input  logic [LVL_W-1:0]       mask_lvl_i,
  input  logic [STAB_W-1:0]      stab_cnt_i,
  input  logic                   hs_clk_lvl_i,
  input  logic                   ls_clk_lvl_i,
  output logic                   hs_osc_en_o,
  output logic                   ls_osc_en_o,
  output logic                   clk_sel_ls_o,
  output logic                   clk_run_o,
  output logic                   cpu_halt_o
);
  localparam int PAD_W = REG_W - MODE_W;

  mode_e             mode_q;
  logic              stab_q;
  logic [STAB_W-1:0] cnt_q;
  logic              wake;
  logic              wr_ok;
  ctl_t              ctl;

  pmc_wake #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_wake (
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .irq_lvl_i (irq_lvl_i),
    .gie_i     (gie_i),
    .mask_lvl_i(mask_lvl_i),
    .wake_o    (wake)
  );

  pmc_mode_decode u_dec (
    .mode_i(mode_q),
    .stab_i(stab_q),
    .ctl_o (ctl)
  );

  pmc_clk_switch u_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .want_ls_i(ctl.src_ls),
    .hold_i   (~ctl.clk_run),
    .hs_lvl_i (hs_clk_lvl_i),
    .ls_lvl_i (ls_clk_lvl_i),
    .sel_ls_o (clk_sel_ls_o)
  );

  assign wr_ok = wr_en_i && (wr_data_i[REG_W-1:MODE_W] == '0) &&
                 mode_legal(wr_data_i[MODE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_NORMAL;
      stab_q <= 1'b0;
      cnt_q  <= '0;
    end else if (stab_q) begin
      if (cnt_q == '0) begin
        mode_q <= (mode_q == M_STOP1) ? M_SLOW : M_NORMAL;
        stab_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      case (mode_q)
        M_HALT0: if (wake) mode_q <= M_NORMAL;
        M_HALT1: if (wake) mode_q <= M_SLOW;
        M_STOP0, M_STOP1: if (wake) begin
          stab_q <= 1'b1;
          cnt_q  <= stab_cnt_i;
        end
        default: if (wr_ok) mode_q <= mode_e'(wr_data_i[MODE_W-1:0]);
      endcase
    end
  end

  assign rd_data_o   = {{PAD_W{1'b0}}, mode_q};
  assign hs_osc_en_o = ctl.hs_en;
  assign ls_osc_en_o = ctl.ls_en;
  assign clk_run_o   = ctl.clk_run;
  assign cpu_halt_o  = ctl.cpu_halt;

  a_r3_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_legal(mode_q));
  a_r7_wake_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake |-> gie_i);
  a_r8_halt0_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_HALT0 && wake) |=> mode_q == M_NORMAL);
  a_r8_halt1_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == M_HALT1 && wake) |=> mode_q == M_SLOW);
  a_r9_stab_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_q |-> (cpu_halt_o && !clk_run_o));
  a_r11_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_halt_o && !wake && !stab_q) |=> $stable(mode_q));
endmodule

// File: tb/pmc_ctrl_tb.sv
module pmc_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = '0;
  logic [7:0]  rd_data_o;
  logic [3:0]  irq_req_i = '0;
  logic [3:0]  irq_en_i = '0;
  logic [11:0] irq_lvl_i = '0;
  logic        gie_i = 1'b0;
  logic [2:0]  mask_lvl_i = 3'd3;
  logic [7:0]  stab_cnt_i = '0;
  logic        hs_clk_lvl_i = 1'b0;
  logic        ls_clk_lvl_i = 1'b0;
  logic        hs_osc_en_o, ls_osc_en_o, clk_sel_ls_o, clk_run_o, cpu_halt_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  pmc_ctrl u_dut (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .rd_data_o,
    .irq_req_i, .irq_en_i, .irq_lvl_i, .gie_i, .mask_lvl_i, .stab_cnt_i,
    .hs_clk_lvl_i, .ls_clk_lvl_i,
    .hs_osc_en_o, .ls_osc_en_o, .clk_sel_ls_o, .clk_run_o, .cpu_halt_o
  );

  // per code: legal, hs, ls, sel (after one settle edge from NORMAL), run, halt
  localparam logic [5:0] VEC [16] = '{
    6'b111010, 6'b111110, 6'b011010, 6'b101110,
    6'b111011, 6'b011010, 6'b011010, 6'b101111,
    6'b100001, 6'b011010, 6'b011010, 6'b100001,
    6'b011010, 6'b011010, 6'b011010, 6'b011010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic outs(output logic [4:0] o);
    o = {hs_osc_en_o, ls_osc_en_o, clk_sel_ls_o, clk_run_o, cpu_halt_o};
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] o;
    irq_lvl_i = {4{3'd2}};
    do_reset();
    outs(o);
    chk("R1 reset rd", {24'd0, rd_data_o}, 32'h00);
    chk("R1 reset outs", {27'd0, o}, {27'd0, 5'b11010});

    // R2 R3 R4 R5 R6: every code from NORMAL
    for (int c = 0; c < 16; c++) begin
      logic [5:0] e;
      e = VEC[c];
      do_reset();
      do_write(8'(c));
      tick(1);
      outs(o);
      chk($sformatf("R2_R3 code %0d rd", c), {24'd0, rd_data_o},
          e[5] ? 32'(c) : 32'h00);
      chk($sformatf("R4_R5_R6 code %0d outs", c), {27'd0, o}, {27'd0, e[4:0]});
    end

    // R3: illegal and nonzero upper nibble from SLOW
    do_reset();
    do_write(8'h03);
    do_write(8'h05);
    chk("R3 illegal from SLOW", {24'd0, rd_data_o}, 32'h03);
    do_write(8'h10);
    chk("R3 upper nibble", {24'd0, rd_data_o}, 32'h03);

    // R10: switch waits for both clock levels low
    do_reset();
    @(negedge clk_i); hs_clk_lvl_i = 1'b1;
    do_write(8'h01);
    tick(2);
    chk("R10 held while fast high", {31'd0, clk_sel_ls_o}, 32'd0);
    hs_clk_lvl_i = 1'b0; ls_clk_lvl_i = 1'b1;
    tick(1);
    chk("R10 held while slow high", {31'd0, clk_sel_ls_o}, 32'd0);
    ls_clk_lvl_i = 1'b0;
    tick(1);
    chk("R10 switch at both low", {31'd0, clk_sel_ls_o}, 32'd1);

    // R7 R8 R11: HALT0 wake qualification
    do_reset();
    do_write(8'h04);
    irq_req_i = 4'b0001; irq_en_i = 4'b0001; gie_i = 1'b0; mask_lvl_i = 3'd3;
    tick(1);
    chk("R7 no wake without gie", {24'd0, rd_data_o}, 32'h04);
    gie_i = 1'b1; irq_en_i = 4'b0000;
    tick(1);
    chk("R7 no wake without enable", {24'd0, rd_data_o}, 32'h04);
    irq_en_i = 4'b0001; mask_lvl_i = 3'd2;
    tick(1);
    chk("R7 no wake at mask level", {24'd0, rd_data_o}, 32'h04);
    irq_req_i = 4'b0000;
    do_write(8'h00);
    chk("R11 write ignored halted", {24'd0, rd_data_o}, 32'h04);
    mask_lvl_i = 3'd3; irq_req_i = 4'b0001;
    tick(1);
    chk("R8 HALT0 to NORMAL", {24'd0, rd_data_o}, 32'h00);
    chk("R8 halt released", {31'd0, cpu_halt_o}, 32'd0);
    irq_req_i = '0;

    // R8: HALT1 to SLOW
    do_reset();
    do_write(8'h03);
    do_write(8'h07);
    irq_req_i = 4'b0001;
    tick(1);
    chk("R8 HALT1 to SLOW", {24'd0, rd_data_o}, 32'h03);
    irq_req_i = '0;

    // R9: STOP0 settle for 3
    do_reset();
    stab_cnt_i = 8'd3;
    do_write(8'h08);
    outs(o);
    chk("R9 STOP0 oscillators off", {27'd0, o}, {27'd0, 5'b00001});
    irq_req_i = 4'b0001;
    tick(1);
    irq_req_i = '0;
    outs(o);
    chk("R9 STOP0 settling outs", {27'd0, o}, {27'd0, 5'b11001});
    tick(3);
    chk("R9 still halted at count end", {31'd0, cpu_halt_o}, 32'd1);
    chk("R9 still STOP0", {24'd0, rd_data_o}, 32'h08);
    tick(1);
    chk("R9 STOP0 to NORMAL", {24'd0, rd_data_o}, 32'h00);
    outs(o);
    chk("R9 running after settle", {27'd0, o}, {27'd0, 5'b11010});

    // R9: STOP1 settle for 0
    do_reset();
    stab_cnt_i = 8'd0;
    do_write(8'h03);
    do_write(8'h0B);
    irq_req_i = 4'b0001;
    tick(1);
    irq_req_i = '0;
    chk("R9 STOP1 halted settling", {29'd0, ls_osc_en_o, hs_osc_en_o, cpu_halt_o}, 32'b101);
    tick(1);
    chk("R9 STOP1 to SLOW", {24'd0, rd_data_o}, 32'h03);
    chk("R9 STOP1 released", {31'd0, cpu_halt_o}, 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule